// File: doc/BRIEF.md
# SGMII Configuration Ordered-Set Generator

This block builds the transmit byte stream that a serial gigabit link sends while auto-negotiation runs. Every cycle it presents one byte with a flag that marks control characters. The bytes go to an external 8b/10b encoder. When configuration mode is requested and the block is not disabled, it sends four-byte configuration ordered sets. These sets take turns between two variants and carry a configuration word supplied by the surrounding logic. In every other case it sends two-byte idle ordered sets.

The word follows the usual negotiation layout: link status in bit 15, duplex in bit 12 and the speed code in bits 11:10. The block does not decode these fields. It only carries the word, low byte first. A change of mode is applied only when one ordered set ends and the next begins, so the encoder never receives a partial set. A strobe marks the first byte of each set.

Top module: `neg_oset_gen`

## Requirements
- R1: A configuration set is four bytes in this order: the comma 0xBC with the control flag set, a variant code, bits 7:0 of the configuration word, then bits 15:8.
- R2: The variant code is 0xB5 for the first variant and 0x42 for the second. Configuration sets take turns strictly, beginning with the first variant after reset. Idle sets sent between configuration sets do not advance or reset this turn-taking.
- R3: An idle set is two bytes: 0xBC with the control flag set, then 0x50 with the flag clear.
- R4: The control flag is high only on the leading comma byte of a set. Every other byte has the flag low.
- R5: The start strobe is high for exactly the cycle that carries the leading comma of every set, and low otherwise.
- R6: The configuration word is captured once, at the boundary where a configuration set begins. Changing it during that set does not alter the set's payload bytes.
- R7: The mode input (1 = configuration, 0 = idle) is sampled only at set boundaries. A change in the middle of a set lets the current set finish unchanged.
- R8: While the disable input is high at a boundary, the next set is an idle set, whatever the mode input says.
- R9: During synchronous active-low reset the output shows 0xBC with the control flag and the strobe high. The first cycle after release shows 0x50, and the turn-taking restarts at the first variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_word_i | input | 16 | Configuration word to advertise |
| cfg_mode_i | input | 1 | 1 requests configuration sets, 0 requests idle sets |
| neg_off_i | input | 1 | Forces idle sets while high |
| tx_byte_o | output | 8 | Byte to the encoder |
| tx_ctrl_o | output | 1 | High when the byte is a control character |
| tx_sos_o | output | 1 | High on the first byte of each ordered set |

## Verification
The bench builds the block with its default parameters: a 16-bit word, 8-bit bytes and the standard code values. With these values each configuration set has exactly two payload bytes, so the order of the low and high bytes can be checked directly. The directed scenarios change the word, the mode and the disable input one cycle after a set starts. They also assert reset halfway through a configuration set. This exercises boundary-only sampling and the restart of the variant turn-taking.

// File: rtl/neg_oset_pkg.sv
package neg_oset_pkg;
   typedef enum logic [1:0] {
      OS_IDLE  = 2'd0,
      OS_CFG_A = 2'd1,
      OS_CFG_B = 2'd2
   } os_kind_t;
endpackage

// File: rtl/neg_oset_seq.sv
module neg_oset_seq
   import neg_oset_pkg::*;
#(
   parameter int CFG_LEN  = 4,
   parameter int IDLE_LEN = 2,
   localparam int POS_W   = $clog2(CFG_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             want_cfg_i,
   output os_kind_t         kind_o,
   output logic [POS_W-1:0] pos_o,
   output logic             capture_o
);
   os_kind_t         kind_q, kind_d;
   logic [POS_W-1:0] pos_q, pos_d;
   logic             alt_q, alt_d;
   logic             last;

   always_comb begin
      if (kind_q == OS_IDLE) last = (pos_q == POS_W'(IDLE_LEN - 1));
      else                   last = (pos_q == POS_W'(CFG_LEN - 1));
   end

   always_comb begin
      kind_d    = kind_q;
      pos_d     = pos_q + 1'b1;
      alt_d     = alt_q;
      capture_o = 1'b0;
      if (last) begin
         pos_d = '0;
         if (want_cfg_i) begin
            kind_d    = alt_q ? OS_CFG_B : OS_CFG_A;
            alt_d     = ~alt_q;
            capture_o = 1'b1;
         end else begin
            kind_d = OS_IDLE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= OS_IDLE;
         pos_q  <= '0;
         alt_q  <= 1'b0;
      end else begin
         kind_q <= kind_d;
         pos_q  <= pos_d;
         alt_q  <= alt_d;
      end
   end

   assign kind_o = kind_q;
   assign pos_o  = pos_q;

   assert_pos_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= POS_W'(CFG_LEN - 1));
   assert_idle_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == OS_IDLE) |-> (pos_q <= POS_W'(IDLE_LEN - 1)));
   assert_alt_turn_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (last && want_cfg_i && kind_q != OS_IDLE) |=> (kind_q != $past(kind_q)));
endmodule

// File: rtl/neg_oset_payload.sv
module neg_oset_payload #(
   parameter int CFG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture_i,
   input  logic [CFG_W-1:0] word_i,
   output logic [CFG_W-1:0] word_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)         word_o <= '0;
      else if (capture_i) word_o <= word_i;
   end
endmodule

// File: rtl/neg_oset_mux.sv
module neg_oset_mux
   import neg_oset_pkg::*;
#(
   parameter int          CFG_W   = 16,
   parameter int          BYTE_W  = 8,
   parameter int          POS_W   = 2,
   parameter logic [7:0]  COMMA   = 8'hBC,
   parameter logic [7:0]  CODE_A  = 8'hB5,
   parameter logic [7:0]  CODE_B  = 8'h42,
   parameter logic [7:0]  CODE_I  = 8'h50,
   localparam int         NPAY    = CFG_W / BYTE_W
) (
   input  os_kind_t          kind_i,
   input  logic [POS_W-1:0]  pos_i,
   input  logic [CFG_W-1:0]  word_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              ctrl_o,
   output logic              sos_o
);
   logic [BYTE_W-1:0] lane [NPAY];

   for (genvar g = 0; g < NPAY; g++) begin : g_lane
      assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
   end

   always_comb begin
      byte_o = '0;
      ctrl_o = 1'b0;
      sos_o  = 1'b0;
      if (pos_i == '0) begin
         byte_o = BYTE_W'(COMMA);
         ctrl_o = 1'b1;
         sos_o  = 1'b1;
      end else if (pos_i == POS_W'(1)) begin
         case (kind_i)
            OS_CFG_A: byte_o = BYTE_W'(CODE_A);
            OS_CFG_B: byte_o = BYTE_W'(CODE_B);
            default:  byte_o = BYTE_W'(CODE_I);
         endcase
      end else begin
         for (int i = 0; i < NPAY; i++) begin
            if (pos_i == POS_W'(i + 2)) byte_o = lane[i];
         end
      end
   end
endmodule

// File: rtl/neg_oset_gen.sv
module neg_oset_gen
   import neg_oset_pkg::*;
#(
   parameter int         CFG_W  = 16,
   parameter int         BYTE_W = 8,
   parameter logic [7:0] COMMA  = 8'hBC,
   parameter logic [7:0] CODE_A = 8'hB5,
   parameter logic [7:0] CODE_B = 8'h42,
   parameter logic [7:0] CODE_I = 8'h50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_W-1:0]  cfg_word_i,
   input  logic              cfg_mode_i,
   input  logic              neg_off_i,
   output logic [BYTE_W-1:0] tx_byte_o,
   output logic              tx_ctrl_o,
   output logic              tx_sos_o
);
   localparam int NPAY     = CFG_W / BYTE_W;
   localparam int CFG_LEN  = 2 + NPAY;
   localparam int IDLE_LEN = 2;
   localparam int POS_W    = $clog2(CFG_LEN);

   if (BYTE_W < 8) begin : g_chk_byte
      $error("BYTE_W must be at least 8");
   end
   if ((CFG_W % BYTE_W) != 0 || NPAY < 1) begin : g_chk_word
      $error("CFG_W must be a nonzero multiple of BYTE_W");
   end

   os_kind_t         kind;
   logic [POS_W-1:0] pos;
   logic             capture;
   logic [CFG_W-1:0] cfg_hold;
   logic             want_cfg;

   assign want_cfg = cfg_mode_i & ~neg_off_i;

   neg_oset_seq #(.CFG_LEN(CFG_LEN), .IDLE_LEN(IDLE_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .want_cfg_i(want_cfg),
      .kind_o(kind), .pos_o(pos), .capture_o(capture)
   );

   neg_oset_payload #(.CFG_W(CFG_W)) u_pay (
      .clk(clk), .rst_n(rst_n), .capture_i(capture),
      .word_i(cfg_word_i), .word_o(cfg_hold)
   );

   neg_oset_mux #(
      .CFG_W(CFG_W), .BYTE_W(BYTE_W), .POS_W(POS_W),
      .COMMA(COMMA), .CODE_A(CODE_A), .CODE_B(CODE_B), .CODE_I(CODE_I)
   ) u_mux (
      .kind_i(kind), .pos_i(pos), .word_i(cfg_hold),
      .byte_o(tx_byte_o), .ctrl_o(tx_ctrl_o), .sos_o(tx_sos_o)
   );

   assert_payload_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != OS_IDLE && !tx_sos_o) |-> $stable(cfg_hold));
   assert_kind_at_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_sos_o |-> $stable(kind));
   assert_off_gives_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_sos_o && $past(neg_off_i) && $past(rst_n)) |-> (kind == OS_IDLE));
   assert_strobe_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_sos_o |=> !tx_sos_o);
   assert_ctrl_comma_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ctrl_o |-> (tx_byte_o == BYTE_W'(COMMA)));
endmodule

// File: tb/tb_neg_oset_gen.sv
module tb_neg_oset_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_word = '0;
   logic        cfg_mode = 1'b0;
   logic        neg_off = 1'b0;
   logic [7:0]  tx_byte;
   logic        tx_ctrl;
   logic        tx_sos;

   int n_run  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   neg_oset_gen dut (
      .clk(clk), .rst_n(rst_n), .cfg_word_i(cfg_word), .cfg_mode_i(cfg_mode),
      .neg_off_i(neg_off), .tx_byte_o(tx_byte), .tx_ctrl_o(tx_ctrl), .tx_sos_o(tx_sos)
   );

   task automatic chk(input logic [7:0] b, input logic k, input logic s, input string tag);
      n_run++;
      if (tx_byte !== b || tx_ctrl !== k || tx_sos !== s) begin
         n_fail++;
         $display("FAIL %s: got byte=%02h ctrl=%b sos=%b, expected byte=%02h ctrl=%b sos=%b",
                  tag, tx_byte, tx_ctrl, tx_sos, b, k, s);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   // Inputs set before calling decide the set that follows this one.
   task automatic exp_idle(input string tag);
      chk(8'hBC, 1'b1, 1'b1, {tag, " R3 R4 R5 idle comma"});
      tick();
      chk(8'h50, 1'b0, 1'b0, {tag, " R3 R4 idle data"});
      tick();
   endtask

   task automatic exp_cfg(input logic [15:0] w, input bit second, input string tag);
      chk(8'hBC, 1'b1, 1'b1, {tag, " R1 R4 R5 cfg comma"});
      tick();
      chk(second ? 8'h42 : 8'hB5, 1'b0, 1'b0, {tag, " R2 variant code"});
      tick();
      chk(w[7:0], 1'b0, 1'b0, {tag, " R1 low byte"});
      tick();
      chk(w[15:8], 1'b0, 1'b0, {tag, " R1 high byte"});
      tick();
   endtask

   task automatic do_reset(input string tag);
      rst_n = 1'b0;
      tick(); tick(); tick();
      chk(8'hBC, 1'b1, 1'b1, {tag, " R9 during reset"});
      rst_n = 1'b1;
      tick();
      chk(8'h50, 1'b0, 1'b0, {tag, " R9 first byte after release"});
      tick();
   endtask

   task automatic t_reset();
      cfg_mode = 1'b0; neg_off = 1'b0;
      do_reset("t_reset");
      exp_idle("t_reset");
      exp_idle("t_reset");
   endtask

   task automatic t_cfg_alt();
      cfg_word = 16'h9401;
      cfg_mode = 1'b1;
      exp_idle("t_cfg_alt R7 idle before switch");
      exp_cfg(16'h9401, 1'b0, "t_cfg_alt first");
      exp_cfg(16'h9401, 1'b1, "t_cfg_alt second");
      exp_cfg(16'h9401, 1'b0, "t_cfg_alt third");
   endtask

   task automatic t_word_change();
      // now at start of a second-variant set carrying 0x9401
      chk(8'hBC, 1'b1, 1'b1, "t_word_change R5 comma");
      cfg_word = 16'h1234;
      tick();
      chk(8'h42, 1'b0, 1'b0, "t_word_change R2 code");
      tick();
      chk(8'h01, 1'b0, 1'b0, "t_word_change R6 low byte kept");
      tick();
      chk(8'h94, 1'b0, 1'b0, "t_word_change R6 high byte kept");
      tick();
      exp_cfg(16'h1234, 1'b0, "t_word_change R6 new word");
   endtask

   task automatic t_mode_mid();
      chk(8'hBC, 1'b1, 1'b1, "t_mode_mid R7 comma");
      cfg_mode = 1'b0;
      tick();
      chk(8'h42, 1'b0, 1'b0, "t_mode_mid R7 set continues");
      tick();
      chk(8'h34, 1'b0, 1'b0, "t_mode_mid R7 low byte");
      tick();
      chk(8'h12, 1'b0, 1'b0, "t_mode_mid R7 high byte");
      tick();
      exp_idle("t_mode_mid R7 after");
      exp_idle("t_mode_mid R7 after");
   endtask

   task automatic t_disable();
      cfg_mode = 1'b1;
      neg_off  = 1'b1;
      exp_idle("t_disable R8");
      exp_idle("t_disable R8 forced");
      exp_idle("t_disable R8 forced");
      neg_off = 1'b0;
      exp_idle("t_disable R8 forced last");
      exp_cfg(16'h1234, 1'b0, "t_disable R2 resume");
      exp_cfg(16'h1234, 1'b1, "t_disable R2 next");
   endtask

   task automatic t_reset_mid();
      exp_cfg(16'h1234, 1'b0, "t_reset_mid before");
      chk(8'hBC, 1'b1, 1'b1, "t_reset_mid R5 comma");
      tick();
      chk(8'h42, 1'b0, 1'b0, "t_reset_mid R2 code");
      do_reset("t_reset_mid");
      exp_cfg(16'h1234, 1'b0, "t_reset_mid R9 restart first variant");
      exp_cfg(16'h1234, 1'b1, "t_reset_mid R2 then second");
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #2;
      t_reset();
      t_cfg_alt();
      t_word_change();
      t_mode_mid();
      t_disable();
      t_reset_mid();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule